// File: doc/BRIEF.md
# Configuration Word Stream Sequencer

This block produces the complete 32-bit word stream that reprograms a programmable-logic fabric through its configuration port. One `start` pulse launches a fixed startup script: a run of register writes that prepares the configuration engine, a frame-data write that passes caller-supplied frame words straight through, and a closing script that restores state, starts the fabric and desynchronises the port. Every packet header and every command payload is built inside the block. The caller supplies only the frame word count, the device identification value and the frame words themselves.

Words leave on a valid/ready stream at up to one word per cycle. Frame words enter on a second valid/ready stream and are forwarded only while the script sits on the frame section. The generator adds 202 zero pad words after the frame data. It emits long idle runs in the closing script: 100 no-op words after the last-frame command and 400 after the desync command. A one-cycle `done` pulse reports that the final word has been accepted downstream.

Top module: `cfg_stream_gen`

## Requirements
- R1: After reset `outValid`, `frameReady`, `busy` and `done` are all 0.
- R2: The opening script emits, in this order: no-op word 0x20000000; timer and warm-boot-address writes of 0; a no-op command; an idle word; a CRC-reset command; two idle words; register 0x13 = 0; startup options; options-1 = 0; identification; a clock-switch command; an idle word; mask 0x401, control-0 0x501, mask 0, control-1 0; eight idle words; frame address 0; a write-config command; an idle word. A single-word write header is 0x30000001 | (register << 13). Register addresses: CMD 0x04, FAR 0x01, FDRI 0x02, CTL0 0x05, MASK 0x06, startup options 0x09, IDCODE 0x0C, options-1 0x0E, warm-boot 0x10, timer 0x11, CTL1 0x18. Command codes: no-op 0x0, write-config 0x1, last-frame 0x3, start 0x5, CRC-reset 0x7, clock-switch 0x9, restore 0xA, desync 0xD.
- R3: The startup-options payload is 0x02003FE5. It sets bit 25; the DONE release field [14:12] is 3; the two stall fields [11:9] and [8:6] are 7; the GTS field [5:3] is 4; the GWE field [2:0] is 5.
- R4: The identification payload equals the `idCode` value captured when `start` was accepted.
- R5: The frame section opens with header 0x30004000, a zero-count write to FDRI. It is followed by the bulk header 0x50000000 | (frameCount + 202), with bits [31:29]=010, write opcode [28:27]=10 and the count in [26:0].
- R6: Exactly `frameCount` frame words are taken from the frame input and emitted unchanged, in arrival order, directly after the bulk header.
- R7: 202 words of 0x00000000 follow the frame words.
- R8: The closing script is: CRC-reset and two idle words; restore and one idle word; last-frame and 100 idle words; start and one idle word; FAR=0x03BE0000, MASK=0x501, CTL0=0x501; CRC-reset and two idle words; desync and 400 idle words. Total stream length is 772 + frameCount words.
- R9: While `outValid` is 1 and `outReady` is 0, `outWord` and `outValid` hold their values.
- R10: `done` is high for exactly one cycle, in the cycle after the final word is accepted, and `busy` is 0 from then on.
- R11: A `start` pulse while `busy` is 1 has no effect on the stream in progress.
- R12: With `frameCount` = 0 no frame word is requested; the bulk header carries 202 and the pad words follow it directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch the script when idle |
| frameCount | input | 27 | Number of frame words, sampled at start |
| idCode | input | 32 | Device identification value, sampled at start |
| frameData | input | 32 | Frame word input |
| frameValid | input | 1 | Frame word present |
| frameReady | output | 1 | Frame word taken this cycle |
| outWord | output | 32 | Configuration word output |
| outValid | output | 1 | Output word present |
| outReady | input | 1 | Downstream accepts the word |
| busy | output | 1 | Script in progress |
| done | output | 1 | One-cycle end-of-stream pulse |

## Verification
A start sampled on one edge produces the first word on the next edge, since it passes through one state register and one output register. After that, each word is due one edge after the previous one is accepted, or one edge after a frame word is offered. `done` is due one edge after the final handshake. The bench sets `outReady` and the frame inputs half a cycle before each edge. It samples a short settle delay later. It records a word only when valid and ready are both high, so every result is compared against the edge on which it must change. The same stream is checked under full-rate, alternating and pseudo-random back-pressure and frame gaps.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

  localparam int WORD_W  = 32;
  localparam int BULK_CW = 27;

  // register addresses
  localparam logic [4:0] RA_FAR    = 5'h01;
  localparam logic [4:0] RA_FDRI   = 5'h02;
  localparam logic [4:0] RA_CMD    = 5'h04;
  localparam logic [4:0] RA_CTL0   = 5'h05;
  localparam logic [4:0] RA_MASK   = 5'h06;
  localparam logic [4:0] RA_OPT0   = 5'h09;
  localparam logic [4:0] RA_IDENT  = 5'h0C;
  localparam logic [4:0] RA_OPT1   = 5'h0E;
  localparam logic [4:0] RA_WBOOT  = 5'h10;
  localparam logic [4:0] RA_TIMER  = 5'h11;
  localparam logic [4:0] RA_MISC13 = 5'h13;
  localparam logic [4:0] RA_CTL1   = 5'h18;

  // command codes
  localparam logic [31:0] CC_NULL     = 32'h0;
  localparam logic [31:0] CC_WRCFG    = 32'h1;
  localparam logic [31:0] CC_LASTFRM  = 32'h3;
  localparam logic [31:0] CC_GO       = 32'h5;
  localparam logic [31:0] CC_CRCRST   = 32'h7;
  localparam logic [31:0] CC_CLKSW    = 32'h9;
  localparam logic [31:0] CC_RESTORE  = 32'hA;
  localparam logic [31:0] CC_DESYNC   = 32'hD;

  localparam logic [31:0] IDLE_WORD = {3'b001, 2'b00, 27'd0};

  typedef enum logic [1:0] {SRC_CONST, SRC_ID, SRC_HDR2, SRC_FRAME} srcKind_e;
  typedef enum logic [2:0] {LK_ONE, LK_TWO, LK_GAP, LK_PAD, LK_FLUSH, LK_TAIL, LK_FRAME} lenKind_e;

  typedef struct packed {
    srcKind_e    src;
    logic [31:0] word;
    lenKind_e    len;
  } scriptEntry_t;

  typedef struct packed {
    logic        capture;
    logic        load;
    srcKind_e    src;
    logic [31:0] constWord;
  } seqStrobe_t;

  localparam int SCRIPT_LEN = 64;
  localparam int IDX_W      = 7;

  function automatic logic [31:0] t1Write(logic [4:0] addr, logic [10:0] cnt);
    return {3'b001, 2'b10, 9'd0, addr, 2'b00, cnt};
  endfunction

  function automatic logic [31:0] t2Write(logic [BULK_CW-1:0] cnt);
    return {3'b010, 2'b10, cnt};
  endfunction

  function automatic logic [31:0] startupOptions();
    return {6'd0, 1'b1, 10'd0, 3'd3, 3'd7, 3'd7, 3'd4, 3'd5};
  endfunction

  function automatic scriptEntry_t mk(srcKind_e s, logic [31:0] w, lenKind_e l);
    scriptEntry_t e;
    e.src = s; e.word = w; e.len = l;
    return e;
  endfunction

  function automatic scriptEntry_t cw(logic [31:0] w);
    return mk(SRC_CONST, w, LK_ONE);
  endfunction

  // The whole script; repeated idle words are single run-length entries.
  function automatic scriptEntry_t scriptAt(logic [IDX_W-1:0] idx);
    case (idx)
      7'd0:  return cw(IDLE_WORD);
      7'd1:  return cw(t1Write(RA_TIMER, 11'd1));
      7'd2:  return cw(32'h0);
      7'd3:  return cw(t1Write(RA_WBOOT, 11'd1));
      7'd4:  return cw(32'h0);
      7'd5:  return cw(t1Write(RA_CMD, 11'd1));
      7'd6:  return cw(CC_NULL);
      7'd7:  return cw(IDLE_WORD);
      7'd8:  return cw(t1Write(RA_CMD, 11'd1));
      7'd9:  return cw(CC_CRCRST);
      7'd10: return mk(SRC_CONST, IDLE_WORD, LK_TWO);
      7'd11: return cw(t1Write(RA_MISC13, 11'd1));
      7'd12: return cw(32'h0);
      7'd13: return cw(t1Write(RA_OPT0, 11'd1));
      7'd14: return cw(startupOptions());
      7'd15: return cw(t1Write(RA_OPT1, 11'd1));
      7'd16: return cw(32'h0);
      7'd17: return cw(t1Write(RA_IDENT, 11'd1));
      7'd18: return mk(SRC_ID, 32'h0, LK_ONE);
      7'd19: return cw(t1Write(RA_CMD, 11'd1));
      7'd20: return cw(CC_CLKSW);
      7'd21: return cw(IDLE_WORD);
      7'd22: return cw(t1Write(RA_MASK, 11'd1));
      7'd23: return cw(32'h401);
      7'd24: return cw(t1Write(RA_CTL0, 11'd1));
      7'd25: return cw(32'h501);
      7'd26: return cw(t1Write(RA_MASK, 11'd1));
      7'd27: return cw(32'h0);
      7'd28: return cw(t1Write(RA_CTL1, 11'd1));
      7'd29: return cw(32'h0);
      7'd30: return mk(SRC_CONST, IDLE_WORD, LK_GAP);
      7'd31: return cw(t1Write(RA_FAR, 11'd1));
      7'd32: return cw(32'h0);
      7'd33: return cw(t1Write(RA_CMD, 11'd1));
      7'd34: return cw(CC_WRCFG);
      7'd35: return cw(IDLE_WORD);
      7'd36: return cw(t1Write(RA_FDRI, 11'd0));
      7'd37: return mk(SRC_HDR2, 32'h0, LK_ONE);
      7'd38: return mk(SRC_FRAME, 32'h0, LK_FRAME);
      7'd39: return mk(SRC_CONST, 32'h0, LK_PAD);
      7'd40: return cw(t1Write(RA_CMD, 11'd1));
      7'd41: return cw(CC_CRCRST);
      7'd42: return mk(SRC_CONST, IDLE_WORD, LK_TWO);
      7'd43: return cw(t1Write(RA_CMD, 11'd1));
      7'd44: return cw(CC_RESTORE);
      7'd45: return cw(IDLE_WORD);
      7'd46: return cw(t1Write(RA_CMD, 11'd1));
      7'd47: return cw(CC_LASTFRM);
      7'd48: return mk(SRC_CONST, IDLE_WORD, LK_FLUSH);
      7'd49: return cw(t1Write(RA_CMD, 11'd1));
      7'd50: return cw(CC_GO);
      7'd51: return cw(IDLE_WORD);
      7'd52: return cw(t1Write(RA_FAR, 11'd1));
      7'd53: return cw(32'h03BE_0000);
      7'd54: return cw(t1Write(RA_MASK, 11'd1));
      7'd55: return cw(32'h501);
      7'd56: return cw(t1Write(RA_CTL0, 11'd1));
      7'd57: return cw(32'h501);
      7'd58: return cw(t1Write(RA_CMD, 11'd1));
      7'd59: return cw(CC_CRCRST);
      7'd60: return mk(SRC_CONST, IDLE_WORD, LK_TWO);
      7'd61: return cw(t1Write(RA_CMD, 11'd1));
      7'd62: return cw(CC_DESYNC);
      7'd63: return mk(SRC_CONST, IDLE_WORD, LK_TAIL);
      default: return cw(IDLE_WORD);
    endcase
  endfunction

endpackage

// File: rtl/cfgseq_ctrl.sv
module cfgseq_ctrl
  import cfgseq_pkg::*;
#(
  parameter int CNT_W      = 27,
  parameter int GAP_NOPS   = 8,
  parameter int PAD_WORDS  = 202,
  parameter int FLUSH_NOPS = 100,
  parameter int TAIL_NOPS  = 400
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] frameCount,
  input  logic             frameValid,
  input  logic             outValid,
  input  logic             outReady,
  output seqStrobe_t       strobe,
  output logic             frameReady,
  output logic             busy,
  output logic             done
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} ctrlState_e;

  ctrlState_e       state;
  logic [IDX_W-1:0] entryIdx;
  logic [CNT_W-1:0] runLeft;
  logic [CNT_W-1:0] cntLatched;

  scriptEntry_t     ent, entNext, advEnt;
  logic [IDX_W-1:0] advIdx;
  logic             loadOk, wordAvail, lastEntry, skipFrame;

  function automatic logic [CNT_W-1:0] lenOf(lenKind_e k, logic [CNT_W-1:0] fc);
    case (k)
      LK_TWO:   return CNT_W'(2);
      LK_GAP:   return CNT_W'(GAP_NOPS);
      LK_PAD:   return CNT_W'(PAD_WORDS);
      LK_FLUSH: return CNT_W'(FLUSH_NOPS);
      LK_TAIL:  return CNT_W'(TAIL_NOPS);
      LK_FRAME: return fc;
      default:  return CNT_W'(1);
    endcase
  endfunction

  always_comb begin
    ent       = scriptAt(entryIdx);
    entNext   = scriptAt(entryIdx + IDX_W'(1));
    skipFrame = (entNext.len == LK_FRAME) && (cntLatched == '0);
    advIdx    = skipFrame ? entryIdx + IDX_W'(2) : entryIdx + IDX_W'(1);
    advEnt    = scriptAt(advIdx);
    lastEntry = (entryIdx == IDX_W'(SCRIPT_LEN - 1));
    loadOk    = !outValid || outReady;
    wordAvail = (ent.src != SRC_FRAME) || frameValid;
  end

  assign frameReady       = (state == ST_RUN) && (ent.src == SRC_FRAME) && loadOk;
  assign strobe.load      = (state == ST_RUN) && loadOk && wordAvail;
  assign strobe.capture   = (state == ST_IDLE) && start;
  assign strobe.src       = ent.src;
  assign strobe.constWord = ent.word;
  assign busy             = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      entryIdx   <= '0;
      runLeft    <= '0;
      cntLatched <= '0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            cntLatched <= frameCount;
            entryIdx   <= '0;
            runLeft    <= lenOf(scriptAt('0).len, frameCount);
            state      <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (strobe.load) begin
            if (runLeft == CNT_W'(1)) begin
              if (lastEntry) begin
                state <= ST_DRAIN;
              end else begin
                entryIdx <= advIdx;
                runLeft  <= lenOf(advEnt.len, cntLatched);
              end
            end else begin
              runLeft <= runLeft - CNT_W'(1);
            end
          end
        end
        default: begin
          if (outValid && outReady) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(outValid && outReady)); // R10
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> $stable(cntLatched)); // R11

endmodule

// File: rtl/cfgseq_dpath.sv
module cfgseq_dpath
  import cfgseq_pkg::*;
#(
  parameter int CNT_W     = 27,
  parameter int PAD_WORDS = 202
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [CNT_W-1:0] frameCount,
  input  logic [31:0]      idCode,
  input  logic [31:0]      frameData,
  input  logic             outReady,
  output logic [31:0]      outWord,
  output logic             outValid
);

  logic [31:0]      idLatched;
  logic [CNT_W-1:0] cntLatched;
  logic [31:0]      nextWord;
  logic [BULK_CW-1:0] bulkCount;

  assign bulkCount = BULK_CW'(cntLatched) + BULK_CW'(PAD_WORDS);

  always_comb begin
    case (strobe.src)
      SRC_ID:    nextWord = idLatched;
      SRC_HDR2:  nextWord = t2Write(bulkCount);
      SRC_FRAME: nextWord = frameData;
      default:   nextWord = strobe.constWord;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idLatched  <= '0;
      cntLatched <= '0;
      outWord    <= '0;
      outValid   <= 1'b0;
    end else begin
      if (strobe.capture) begin
        idLatched  <= idCode;
        cntLatched <= frameCount;
      end
      if (strobe.load) begin
        outWord  <= nextWord;
        outValid <= 1'b1;
      end else if (outReady) begin
        outValid <= 1'b0;
      end
    end
  end

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outWord))); // R9

endmodule

// File: rtl/cfg_stream_gen.sv
module cfg_stream_gen
  import cfgseq_pkg::*;
#(
  parameter int CNT_W      = 27,
  parameter int GAP_NOPS   = 8,
  parameter int PAD_WORDS  = 202,
  parameter int FLUSH_NOPS = 100,
  parameter int TAIL_NOPS  = 400
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] frameCount,
  input  logic [31:0]      idCode,
  input  logic [31:0]      frameData,
  input  logic             frameValid,
  output logic             frameReady,
  output logic [31:0]      outWord,
  output logic             outValid,
  input  logic             outReady,
  output logic             busy,
  output logic             done
);

  seqStrobe_t strobe;

  cfgseq_ctrl #(
    .CNT_W(CNT_W), .GAP_NOPS(GAP_NOPS), .PAD_WORDS(PAD_WORDS),
    .FLUSH_NOPS(FLUSH_NOPS), .TAIL_NOPS(TAIL_NOPS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .frameCount(frameCount),
    .frameValid(frameValid), .outValid(outValid), .outReady(outReady),
    .strobe(strobe), .frameReady(frameReady), .busy(busy), .done(done)
  );

  cfgseq_dpath #(.CNT_W(CNT_W), .PAD_WORDS(PAD_WORDS)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .frameCount(frameCount),
    .idCode(idCode), .frameData(frameData), .outReady(outReady),
    .outWord(outWord), .outValid(outValid)
  );

  AST_FRAME_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && frameReady) |=> (outValid && outWord == $past(frameData))); // R6
  AST_NO_FRAME_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !frameReady); // R12

endmodule

// File: tb/cfg_stream_gen_tb_top.sv
module cfg_stream_gen_tb_top;

  localparam int NRUN = 4;
  // stimulus: frame count, back-pressure mode; expected: stream length
  localparam int VEC_COUNT[NRUN] = '{3, 0, 6, 1};
  localparam int VEC_MODE [NRUN] = '{0, 1, 2, 3};
  localparam int VEC_TOTAL[NRUN] = '{775, 772, 778, 773};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [26:0] frameCount = '0;
  logic [31:0] idCode = '0;
  logic [31:0] frameData = '0;
  logic        frameValid = 1'b0;
  logic        frameReady;
  logic [31:0] outWord;
  logic        outValid;
  logic        outReady = 1'b0;
  logic        busy;
  logic        done;

  always #4 clk = ~clk;

  cfg_stream_gen dut_i (
    .clk(clk), .rstN(rstN), .start(start), .frameCount(frameCount),
    .idCode(idCode), .frameData(frameData), .frameValid(frameValid),
    .frameReady(frameReady), .outWord(outWord), .outValid(outValid),
    .outReady(outReady), .busy(busy), .done(done)
  );

  int nChk = 0;
  int nBad = 0;
  int cyc  = 0;
  bit timedOut = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [31:0] expW[0:1023];
  string       expT[0:1023];
  int          expN;

  task automatic check(bit ok, string tag, logic [31:0] got, logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic put(logic [31:0] w, string tag);
    expW[expN] = w; expT[expN] = tag; expN++;
  endtask

  task automatic idles(int n, string tag);
    for (int i = 0; i < n; i++) put(32'h2000_0000, tag);
  endtask

  task automatic buildExpected(int n, logic [31:0] id, logic [31:0] base);
    expN = 0;
    // R2 opening script
    put(32'h2000_0000, "R2"); put(32'h3002_2001, "R2"); put(32'h0, "R2");
    put(32'h3002_0001, "R2"); put(32'h0, "R2");
    put(32'h3000_8001, "R2"); put(32'h0, "R2"); idles(1, "R2");
    put(32'h3000_8001, "R2"); put(32'h7, "R2"); idles(2, "R2");
    put(32'h3002_6001, "R2"); put(32'h0, "R2");
    put(32'h3001_2001, "R2"); put(32'h0200_3FE5, "R3");
    put(32'h3001_C001, "R2"); put(32'h0, "R2");
    put(32'h3001_8001, "R2"); put(id, "R4");
    put(32'h3000_8001, "R2"); put(32'h9, "R2"); idles(1, "R2");
    put(32'h3000_C001, "R2"); put(32'h401, "R2");
    put(32'h3000_A001, "R2"); put(32'h501, "R2");
    put(32'h3000_C001, "R2"); put(32'h0, "R2");
    put(32'h3003_0001, "R2"); put(32'h0, "R2");
    idles(8, "R2");
    put(32'h3000_2001, "R2"); put(32'h0, "R2");
    put(32'h3000_8001, "R2"); put(32'h1, "R2"); idles(1, "R2");
    // R5 frame headers, R12 when count is zero
    put(32'h3000_4000, "R5");
    put(32'h5000_0000 | (n + 202), (n == 0) ? "R12" : "R5");
    for (int i = 0; i < n; i++) put(base + i, "R6");
    for (int i = 0; i < 202; i++) put(32'h0, "R7");
    // R8 closing script
    put(32'h3000_8001, "R8"); put(32'h7, "R8"); idles(2, "R8");
    put(32'h3000_8001, "R8"); put(32'hA, "R8"); idles(1, "R8");
    put(32'h3000_8001, "R8"); put(32'h3, "R8"); idles(100, "R8");
    put(32'h3000_8001, "R8"); put(32'h5, "R8"); idles(1, "R8");
    put(32'h3000_2001, "R8"); put(32'h03BE_0000, "R8");
    put(32'h3000_C001, "R8"); put(32'h501, "R8");
    put(32'h3000_A001, "R8"); put(32'h501, "R8");
    put(32'h3000_8001, "R8"); put(32'h7, "R8"); idles(2, "R8");
    put(32'h3000_8001, "R8"); put(32'hD, "R8"); idles(400, "R8");
  endtask

  task automatic runOne(int r);
    int n = VEC_COUNT[r];
    int mode = VEC_MODE[r];
    logic [31:0] base = 32'hF000_0000 + (r << 16);
    logic [31:0] id = 32'h1362_D093 ^ r;
    int acc = 0;
    int fi = 0;
    bit doneSeen = 0;
    bit holdPend = 0;
    logic [31:0] holdWord = '0;
    int runStart;
    buildExpected(n, id, base);
    @(negedge clk);
    frameCount = 27'(n); idCode = id; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    runStart = cyc;
    while (!doneSeen && !timedOut) begin
      @(negedge clk);
      cyc++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (mode)
        0: outReady = 1'b1;
        1: outReady = cyc[0];
        2: outReady = lfsr[0] | lfsr[1];
        default: outReady = lfsr[2];
      endcase
      frameValid = (fi < n) && ((mode < 2) || lfsr[3] || lfsr[4]);
      frameData  = base + fi;
      // R11: a second start with a different count mid-stream
      start = (mode == 2) && (cyc - runStart == 40);
      if (start) begin frameCount = 27'd50; idCode = 32'hDEAD_BEEF; end
      #1;
      if (holdPend) begin
        check(outValid && outWord == holdWord, "R9", outWord, holdWord);
        holdPend = 0;
      end
      if (outValid && !outReady) begin holdPend = 1; holdWord = outWord; end
      if (outValid && outReady) begin
        if (acc < expN) check(outWord == expW[acc], expT[acc], outWord, expW[acc]);
        else check(1'b0, "R8", outWord, 32'h0);
        acc++;
      end
      if (frameValid && frameReady) fi++;
      if (n == 0 && frameReady) check(1'b0, "R12", 32'h1, 32'h0);
      if (done) begin
        doneSeen = 1;
        check(acc == VEC_TOTAL[r], "R10", acc, VEC_TOTAL[r]);
      end
      if (cyc > 150000) begin
        timedOut = 1;
        check(1'b0, "R10", acc, VEC_TOTAL[r]);
      end
    end
    start = 1'b0; frameValid = 1'b0;
    check(acc == VEC_TOTAL[r], "R8", acc, VEC_TOTAL[r]);
    check(fi == n, "R6", fi, n);
    @(negedge clk); cyc++;
    check(!done, "R10", done, 0);
    check(!busy, "R10", busy, 0);
  endtask

  initial begin
    outReady = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!outValid, "R1", outValid, 0);
    check(!busy, "R1", busy, 0);
    check(!done, "R1", done, 0);
    check(!frameReady, "R1", frameReady, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !outValid, "R1", {busy, outValid}, 0);

    for (int r = 0; r < NRUN; r++) if (!timedOut) runOne(r);

    // reset mid-stream returns to the idle state
    if (!timedOut) begin
      outReady = 1'b1; frameCount = 27'd2; start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (20) @(negedge clk);
      check(busy && outValid, "R2", {busy, outValid}, 2'b11);
      rstN = 1'b0;
      @(negedge clk);
      check(!busy && !outValid && !done && !frameReady, "R1",
            {busy, outValid, done, frameReady}, 0);
      rstN = 1'b1;
      @(negedge clk);
      check(!busy, "R1", busy, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule